// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block sits between a synchronous host and an external asynchronous static RAM with an 8-bit data bus. The host sees a simple valid/ready request port that carries an address, write data and a write flag. It also sees a one-cycle read-data valid pulse. The block turns each accepted request into a correctly timed cycle on the memory pins. It drives the address, the two chip enables of opposite polarity, the output enable and the write strobe. Every analog minimum and maximum becomes a whole number of clock cycles.

Writes are strobe-controlled late writes. The chip is selected with the address already stable. The write strobe is then held low long enough to cover both its own minimum width and the data setup time before its rising edge. The data driver stays on for one cycle after the strobe rises. Reads select the chip and lower the output enable. The returned byte is sampled once the worse of the address-access and output-enable-access limits has expired.

Between cycles the host can request low-power standby. The active-high chip enable then drops and stays low until the next request is accepted, even if the standby request is withdrawn. All limits are given as parameters in picoseconds together with the clock period. Each limit is rounded up to cycles.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: During and right after a synchronous active-low reset, req_ready is 1, mem_cs_n is 1, mem_cs is 1, mem_oe_n is 1, mem_wr_n is 1, mem_dq_oe is 0 and rd_valid is 0.
- R2: When the block is idle, no request is present and stby_req is 1, mem_cs goes to 0 on the next cycle. In standby, mem_cs_n, mem_oe_n and mem_wr_n are 1 and mem_dq_oe is 0. mem_cs stays 0 after stby_req falls, until a request is accepted.
- R3: A request that arrives together with stby_req while idle is served first. A request presented in standby is accepted directly, and mem_cs returns to 1 in the cycle after acceptance. Standby is entered again after the cycle ends only if stby_req is still 1.
- R4: A write selects the chip (mem_cs_n=0) with the address stable for ceil(T_AS/clock) cycles before mem_wr_n falls. It then holds mem_wr_n low for max(ceil(T_WP/clock), ceil(T_DS/clock)) cycles, which is 1 and 6 cycles at a 5 ns clock. mem_oe_n stays 1 throughout.
- R5: mem_dq_oe is 1 only while mem_wr_n is 0 and for exactly one cycle after it rises. mem_dq_out carries the accepted write byte for that whole time.
- R6: A read holds mem_cs_n=0, mem_oe_n=0 and mem_wr_n=1 for max(ceil(T_ACC/clock), ceil(T_OE/clock)) cycles, which is 10 at 5 ns. It samples mem_dq_in at the end of the last of these cycles. rd_valid is then 1 for exactly one cycle with that byte on rd_data.
- R7: req_ready is 1 only while no memory cycle is in progress. A request is accepted on a clock edge where req_valid and req_ready are both 1. A request held while busy waits and is accepted when the block is next idle, which may be the same cycle in which rd_valid is 1.
- R8: mem_addr holds the accepted address, unchanged, for the whole time mem_cs_n is 0 during a cycle. At least one deselected cycle separates two memory cycles.
- R9: mem_wr_n and mem_oe_n are never 0 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_write | input | 1 | 1 for a write request, 0 for a read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write byte |
| rd_valid | output | 1 | One-cycle pulse: rd_data holds read result |
| rd_data | output | DATA_W | Captured read byte |
| stby_req | input | 1 | Request low-power standby between cycles |
| mem_addr | output | ADDR_W | Memory address pins |
| mem_cs_n | output | 1 | Active-low chip enable |
| mem_cs | output | 1 | Active-high chip enable (low forces standby) |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_wr_n | output | 1 | Active-low write strobe |
| mem_dq_out | output | DATA_W | Data driven toward the memory |
| mem_dq_oe | output | 1 | Enable for the data bus driver |
| mem_dq_in | input | DATA_W | Data returned by the memory |

## Verification
Two functions can fall in the same cycle: taking a new request and entering standby. The bench raises stby_req on the same edge that presents a write. The reference model requires that the write is accepted, that mem_cs stays high for the whole cycle, and that standby begins only after the deselected cycle that ends the write. A read then issued from standby with stby_req still high must leave standby immediately and return to it afterwards. A behavioural memory model checks every strobe width, address setup, data window and access time in cycles. Its read data turns wrong when sampled one cycle early.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
// Shared types and helpers for the asynchronous SRAM cycle controller.
// Assumes all timing limits are given in picoseconds as positive integers.
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,   // chip deselected, ready for a request
        PH_STBY = 3'd1,   // low-power standby, active-high enable low
        PH_WSET = 3'd2,   // chip selected, address settling before strobe
        PH_WSTB = 3'd3,   // write strobe low, data driven
        PH_WHLD = 3'd4,   // strobe released, data held one cycle
        PH_READ = 3'd5    // chip and output enable asserted, waiting access
    } phase_e;

    typedef struct packed {
        logic cs_n;
        logic cs;
        logic oe_n;
        logic wr_n;
        logic dq_oe;
    } pins_t;

    // Whole cycles needed to cover t_ps, rounded up, never below one.
    function automatic int ceil_cycles(int t_ps, int clk_ps);
        int r;
        r = (t_ps + clk_ps - 1) / clk_ps;
        if (r < 1) r = 1;
        return r;
    endfunction

    function automatic int max2(int a, int b);
        return (a > b) ? a : b;
    endfunction

    // Memory control pin levels for each phase.
    function automatic pins_t pins_for(phase_e ph);
        pins_t p;
        p = '{cs_n: 1'b1, cs: 1'b1, oe_n: 1'b1, wr_n: 1'b1, dq_oe: 1'b0};
        case (ph)
            PH_STBY: p.cs = 1'b0;
            PH_WSET: p.cs_n = 1'b0;
            PH_WSTB: begin p.cs_n = 1'b0; p.wr_n = 1'b0; p.dq_oe = 1'b1; end
            PH_WHLD: begin p.cs_n = 1'b0; p.dq_oe = 1'b1; end
            PH_READ: begin p.cs_n = 1'b0; p.oe_n = 1'b0; end
            default: ;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
`timescale 1ns/1ps
// Down-counter that times one phase of a memory cycle.
// Assumes: load is pulsed on phase entry with (cycles - 1); last is high
// in the final cycle of the phase.
module sram_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);
    logic [CNT_W-1:0] cnt;

    // Reload on phase entry, otherwise count down to zero and stop.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (load)         cnt <= load_val;
        else if (cnt != '0)    cnt <= cnt - 1'b1;
    end

    assign last = (cnt == '0);
endmodule

// File: rtl/sram_cycle_fsm.sv
`timescale 1ns/1ps
// Phase sequencer: accepts requests, chooses write or read sequence,
// handles standby entry/exit and tells the timer how long each phase lasts.
// Assumes: timer 'last' refers to the current phase's final cycle.
module sram_cycle_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int N_AS  = 1,
    parameter int N_WP  = 6,
    parameter int N_RD  = 10,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             stby_req,
    input  logic             last,
    output phase_e           phase_nxt,
    output logic             req_ready,
    output logic             accept,
    output logic             capture,
    output logic             load,
    output logic [CNT_W-1:0] load_val
);
    phase_e phase;

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_IDLE;
        else        phase <= phase_nxt;
    end

    assign req_ready = (phase == PH_IDLE) || (phase == PH_STBY);
    assign accept    = req_ready && req_valid;
    assign capture   = (phase == PH_READ) && last;

    // Next-phase selection; a request always wins over standby.
    always_comb begin
        phase_nxt = phase;
        case (phase)
            PH_IDLE, PH_STBY: begin
                if (req_valid)                         phase_nxt = req_write ? PH_WSET : PH_READ;
                else if (phase == PH_IDLE && stby_req) phase_nxt = PH_STBY;
            end
            PH_WSET: if (last) phase_nxt = PH_WSTB;
            PH_WSTB: if (last) phase_nxt = PH_WHLD;
            PH_WHLD: phase_nxt = PH_IDLE;
            PH_READ: if (last) phase_nxt = PH_IDLE;
            default: phase_nxt = PH_IDLE;
        endcase
    end

    // Timer reload value for the phase being entered.
    always_comb begin
        load = (phase_nxt != phase);
        case (phase_nxt)
            PH_WSET: load_val = CNT_W'(N_AS - 1);
            PH_WSTB: load_val = CNT_W'(N_WP - 1);
            PH_READ: load_val = CNT_W'(N_RD - 1);
            default: load_val = '0;
        endcase
    end
endmodule

// File: rtl/sram_pin_driver.sv
`timescale 1ns/1ps
// Registers every memory-side output so the pins change only on clock edges.
// Assumes: 'accept' marks the edge on which the host request is taken.
module sram_pin_driver
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  phase_e            phase_nxt,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output pins_t             pins
);
    // Control pins follow the phase being entered.
    always_ff @(posedge clk) begin
        if (!rst_n) pins <= pins_for(PH_IDLE);
        else        pins <= pins_for(phase_nxt);
    end

    // Address and write byte are latched once per accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr   <= '0;
            mem_dq_out <= '0;
        end else if (accept) begin
            mem_addr   <= req_addr;
            mem_dq_out <= req_wdata;
        end
    end
endmodule

// File: rtl/sram_read_capture.sv
`timescale 1ns/1ps
// Samples the memory data bus at the end of the read access window and
// presents it to the host with a one-cycle valid pulse.
// Assumes: 'capture' is high only in the last cycle of a read.
module sram_read_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    // Capture register and valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= capture;
            if (capture) rd_data <= mem_dq_in;
        end
    end
endmodule

// File: rtl/sram_cycle_ctrl.sv
`timescale 1ns/1ps
// Top level: synchronous request port to asynchronous 8-bit SRAM cycles.
// Assumes: all *_PS limits and CLK_PS are in picoseconds; each limit is
// rounded up to whole clock cycles.
module sram_cycle_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W   = 13,
    parameter int DATA_W   = 8,
    parameter int CLK_PS   = 5000,
    parameter int T_AS_PS  = 5000,    // address setup before strobe fall
    parameter int T_WP_PS  = 25000,   // strobe low width
    parameter int T_DS_PS  = 30000,   // data setup before strobe rise
    parameter int T_ACC_PS = 50000,   // access from address / chip enable
    parameter int T_OE_PS  = 15000    // access from output enable
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    input  logic              stby_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_cs,
    output logic              mem_oe_n,
    output logic              mem_wr_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int N_AS  = ceil_cycles(T_AS_PS, CLK_PS);
    localparam int N_WP  = max2(ceil_cycles(T_WP_PS, CLK_PS), ceil_cycles(T_DS_PS, CLK_PS));
    localparam int N_RD  = max2(ceil_cycles(T_ACC_PS, CLK_PS), ceil_cycles(T_OE_PS, CLK_PS));
    localparam int N_MAX = max2(N_AS, max2(N_WP, N_RD));
    localparam int CNT_W = (N_MAX > 1) ? $clog2(N_MAX) : 1;

    phase_e           phase_nxt;
    logic             accept;
    logic             capture;
    logic             load;
    logic [CNT_W-1:0] load_val;
    logic             last;
    pins_t            pins;

    sram_cycle_fsm #(
        .N_AS(N_AS), .N_WP(N_WP), .N_RD(N_RD), .CNT_W(CNT_W)
    ) fsm_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .stby_req(stby_req), .last(last), .phase_nxt(phase_nxt),
        .req_ready(req_ready), .accept(accept), .capture(capture),
        .load(load), .load_val(load_val)
    );

    sram_phase_timer #(.CNT_W(CNT_W)) timer_i (
        .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val), .last(last)
    );

    sram_pin_driver #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) pins_i (
        .clk(clk), .rst_n(rst_n), .phase_nxt(phase_nxt), .accept(accept),
        .req_addr(req_addr), .req_wdata(req_wdata), .mem_addr(mem_addr),
        .mem_dq_out(mem_dq_out), .pins(pins)
    );

    sram_read_capture #(.DATA_W(DATA_W)) rcap_i (
        .clk(clk), .rst_n(rst_n), .capture(capture), .mem_dq_in(mem_dq_in),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    assign mem_cs_n  = pins.cs_n;
    assign mem_cs    = pins.cs;
    assign mem_oe_n  = pins.oe_n;
    assign mem_wr_n  = pins.wr_n;
    assign mem_dq_oe = pins.dq_oe;
endmodule

// File: rtl/sram_cycle_ctrl_chk.sv
`timescale 1ns/1ps
// Protocol checker for the SRAM cycle controller, attached by bind.
// Assumes the same timing parameters as the controller it observes.
module sram_cycle_ctrl_chk
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W  = 13,
    parameter int CLK_PS  = 5000,
    parameter int T_WP_PS = 25000,
    parameter int T_DS_PS = 30000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rd_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_cs_n,
    input logic              mem_cs,
    input logic              mem_oe_n,
    input logic              mem_wr_n,
    input logic              mem_dq_oe
);
    localparam int N_WP = max2(ceil_cycles(T_WP_PS, CLK_PS), ceil_cycles(T_DS_PS, CLK_PS));

    logic [15:0] low_cnt;

    // Length of the current write-strobe low pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)         low_cnt <= '0;
        else if (!mem_wr_n) low_cnt <= low_cnt + 1'b1;
        else                low_cnt <= '0;
    end

    AST_STBY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_cs |-> (mem_cs_n && mem_wr_n && mem_oe_n && !mem_dq_oe)); // R2

    AST_WR_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_wr_n) |-> ($past(!mem_cs_n) && $stable(mem_addr))); // R4

    AST_WR_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_wr_n) |-> (low_cnt >= 16'(N_WP))); // R4

    AST_DQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_wr_n) |-> mem_dq_oe); // R5

    AST_DQ_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> !mem_wr_n); // R5

    AST_RDV_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid); // R6

    AST_RDV_AFTER_OE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(!mem_oe_n)); // R6

    AST_READY_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> mem_cs_n); // R7

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr)); // R8

    AST_WR_OE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_n || mem_oe_n)); // R9
endmodule

bind sram_cycle_ctrl sram_cycle_ctrl_chk #(
    .ADDR_W(ADDR_W), .CLK_PS(CLK_PS), .T_WP_PS(T_WP_PS), .T_DS_PS(T_DS_PS)
) chk_i (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rd_valid(rd_valid),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_cs(mem_cs),
    .mem_oe_n(mem_oe_n), .mem_wr_n(mem_wr_n), .mem_dq_oe(mem_dq_oe)
);

// File: tb/sram_cycle_ctrl_tb_top.sv
`timescale 1ns/1ps
// Bench: cycle reference model plus a behavioural SRAM that checks timing.
module sram_cycle_ctrl_tb_top;
    localparam int AW = 13;
    localparam int DW = 8;
    localparam int CLK_NS = 5;
    localparam int N_AS_TB = (5 + CLK_NS - 1) / CLK_NS;
    localparam int N_WP_TB = ((30 + CLK_NS - 1) / CLK_NS > (25 + CLK_NS - 1) / CLK_NS) ?
                             (30 + CLK_NS - 1) / CLK_NS : (25 + CLK_NS - 1) / CLK_NS;
    localparam int N_RD_TB = (50 + CLK_NS - 1) / CLK_NS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0, stby_req = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic req_ready, rd_valid, mem_cs_n, mem_cs, mem_oe_n, mem_wr_n, mem_dq_oe;
    logic [DW-1:0] rd_data, mem_dq_out;
    logic [DW-1:0] mem_dq_in = '0;
    logic [AW-1:0] mem_addr;

    int n_checks = 0, n_err = 0;
    bit armed = 0;

    always #2.5 clk = ~clk;

    sram_cycle_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .stby_req(stby_req),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_cs(mem_cs),
        .mem_oe_n(mem_oe_n), .mem_wr_n(mem_wr_n), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    task automatic chk(bit ok, string tag, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] init_byte(int a);
        return 8'((a * 37 + 11) & 255);
    endfunction

    logic [7:0] sram_mem [int];
    logic [7:0] shadow [int];

    function automatic logic [7:0] sram_byte(int a);
        return sram_mem.exists(a) ? sram_mem[a] : init_byte(a);
    endfunction
    function automatic logic [7:0] expect_byte(int a);
        return shadow.exists(a) ? shadow[a] : init_byte(a);
    endfunction

    // ---------------- cycle reference model (updated on each edge) ----------
    // modes: 0 idle, 1 standby, 2 write setup, 3 strobe low, 4 hold, 5 read
    int m_mode = 0, m_cnt = 0;
    int m_addr = 0;
    logic [7:0] m_data = '0, e_rdata = '0;
    bit e_rdv = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_cnt = 0; e_rdv = 0;
        end else begin
            e_rdv = 0;
            case (m_mode)
                0, 1: begin
                    if (req_valid) begin
                        m_addr = int'(req_addr); m_data = req_wdata;
                        if (req_write) begin
                            m_mode = 2; m_cnt = N_AS_TB; shadow[int'(req_addr)] = req_wdata;
                        end else begin
                            m_mode = 5; m_cnt = N_RD_TB;
                        end
                    end else if (m_mode == 0 && stby_req) m_mode = 1;
                end
                2: begin m_cnt--; if (m_cnt == 0) begin m_mode = 3; m_cnt = N_WP_TB; end end
                3: begin m_cnt--; if (m_cnt == 0) m_mode = 4; end
                4: m_mode = 0;
                5: begin
                    m_cnt--;
                    if (m_cnt == 0) begin e_rdv = 1; e_rdata = expect_byte(m_addr); m_mode = 0; end
                end
                default: m_mode = 0;
            endcase
        end
    end

    // Compare every port against the model, mid-cycle.
    always @(negedge clk) begin
        if (armed) begin
            chk(req_ready == (m_mode <= 1), "R7 req_ready", req_ready, m_mode <= 1);
            chk(mem_cs == (m_mode != 1), "R2 mem_cs", mem_cs, m_mode != 1);
            chk(mem_cs_n == !(m_mode >= 2), "R3 mem_cs_n", mem_cs_n, !(m_mode >= 2));
            chk(mem_wr_n == (m_mode != 3), "R4 mem_wr_n", mem_wr_n, m_mode != 3);
            chk(mem_oe_n == (m_mode != 5), "R6 mem_oe_n", mem_oe_n, m_mode != 5);
            chk(mem_dq_oe == (m_mode == 3 || m_mode == 4), "R5 mem_dq_oe", mem_dq_oe,
                m_mode == 3 || m_mode == 4);
            if (m_mode == 3 || m_mode == 4)
                chk(mem_dq_out == m_data, "R5 mem_dq_out", mem_dq_out, m_data);
            if (m_mode >= 2)
                chk(int'(mem_addr) == m_addr, "R8 mem_addr", mem_addr, m_addr);
            chk(rd_valid == e_rdv, "R6 rd_valid", rd_valid, e_rdv);
            if (e_rdv) chk(rd_data == e_rdata, "R6 rd_data", rd_data, e_rdata);
            chk(mem_wr_n || mem_oe_n, "R9 strobe/output-enable overlap", {mem_wr_n, mem_oe_n}, 3);
        end
    end

    // ---------------- behavioural SRAM with cycle-counted timing checks ----
    logic p_wr = 1, p_sel = 0, p_rd = 0, p_dqoe = 0;
    logic [AW-1:0] p_addr = '0;
    logic [DW-1:0] p_data = '0;
    int a_stab = 0, d_stab = 0, w_cnt = 0, r_cnt = 0;

    always @(negedge clk) begin
        logic sel, rd_cond;
        sel = !mem_cs_n && mem_cs;
        rd_cond = sel && !mem_oe_n && mem_wr_n;
        if (!rst_n) begin
            p_wr = 1; p_sel = 0; p_rd = 0; p_dqoe = 0; a_stab = 0; d_stab = 0; w_cnt = 0; r_cnt = 0;
        end else begin
            a_stab = (sel && p_sel && mem_addr == p_addr) ? a_stab + 1 : 0;
            if (p_wr && !mem_wr_n)
                chk(a_stab >= N_AS_TB && sel, "R4 address setup before strobe", a_stab, N_AS_TB);
            if (!p_wr && mem_wr_n) begin
                chk(w_cnt >= N_WP_TB, "R4 strobe low width", w_cnt, N_WP_TB);
                chk(d_stab >= N_WP_TB, "R5 data setup before strobe rise", d_stab, N_WP_TB);
                chk(mem_dq_oe && mem_dq_out == p_data, "R5 data hold after strobe", mem_dq_oe, 1);
                sram_mem[int'(p_addr)] = p_data;
            end
            w_cnt = !mem_wr_n ? w_cnt + 1 : 0;
            d_stab = (mem_dq_oe && p_dqoe && mem_dq_out == p_data) ? d_stab + 1 : (mem_dq_oe ? 1 : 0);
            r_cnt = (rd_cond && p_rd && mem_addr == p_addr) ? r_cnt + 1 : (rd_cond ? 1 : 0);
            mem_dq_in = (rd_cond && r_cnt >= N_RD_TB) ? sram_byte(int'(mem_addr))
                                                      : ~sram_byte(int'(mem_addr));
            p_wr = mem_wr_n; p_sel = sel; p_rd = rd_cond; p_dqoe = mem_dq_oe;
            p_addr = mem_addr; p_data = mem_dq_out;
        end
    end

    // ---------------- stimulus ---------------------------------------------
    task automatic issue(bit wr, logic [AW-1:0] a, logic [DW-1:0] d);
        bit was_ready;
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
        forever begin
            was_ready = req_ready;
            @(negedge clk);
            if (was_ready) break;
        end
        req_valid = 0;
    endtask

    task automatic read_check(logic [AW-1:0] a, string tag);
        logic [7:0] exp;
        bit seen;
        exp = expect_byte(int'(a));
        issue(0, a, '0);
        seen = 0;
        for (int i = 0; i < 40 && !seen; i++) begin
            if (rd_valid) seen = 1; else @(negedge clk);
        end
        chk(seen && rd_data == exp, tag, rd_data, exp);
    endtask

    initial begin : main
        repeat (3) @(negedge clk);
        // R1: reset values
        chk(req_ready == 1, "R1 reset req_ready", req_ready, 1);
        chk(mem_cs_n == 1 && mem_cs == 1, "R1 reset chip enables", {mem_cs_n, mem_cs}, 3);
        chk(mem_oe_n == 1 && mem_wr_n == 1, "R1 reset oe/strobe", {mem_oe_n, mem_wr_n}, 3);
        chk(mem_dq_oe == 0 && rd_valid == 0, "R1 reset dq_oe/rd_valid", {mem_dq_oe, rd_valid}, 0);
        rst_n = 1; armed = 1;
        @(negedge clk);
        // R4 R5: writes at boundary addresses and data
        issue(1, 13'h0000, 8'hA5);
        issue(1, 13'h1FFF, 8'h3C);
        issue(1, 13'h0155, 8'hFF);
        issue(1, 13'h0AAA, 8'h00);
        repeat (3) @(negedge clk);
        // R6: read-back and an unwritten location
        read_check(13'h0000, "R6 read 0000");
        read_check(13'h1FFF, "R6 read 1FFF");
        read_check(13'h0155, "R6 read 0155");
        read_check(13'h0AAA, "R6 read 0AAA");
        read_check(13'h0777, "R6 read unwritten");
        // R7: chained requests held while busy (read then write then read)
        issue(0, 13'h0155, '0);
        issue(1, 13'h0155, 8'h81);
        issue(0, 13'h0155, '0);
        issue(0, 13'h1234, '0);
        repeat (14) @(negedge clk);
        read_check(13'h0155, "R7 chained write visible");
        // R2: standby entry and persistence
        stby_req = 1;
        repeat (4) @(negedge clk);
        chk(mem_cs == 0, "R2 standby entered", mem_cs, 0);
        stby_req = 0;
        repeat (4) @(negedge clk);
        chk(mem_cs == 0, "R2 standby persists after request drops", mem_cs, 0);
        chk(req_ready == 1, "R3 ready in standby", req_ready, 1);
        // R3: request from standby
        read_check(13'h1FFF, "R3 read from standby");
        @(negedge clk);
        chk(mem_cs == 1, "R3 standby left after request", mem_cs, 1);
        // R3: request and standby in the same cycle
        stby_req = 1;
        issue(1, 13'h0100, 8'h5A);
        chk(mem_cs == 1, "R3 request wins over standby", mem_cs, 1);
        repeat (10) @(negedge clk);
        chk(mem_cs == 0, "R3 standby after write with request held", mem_cs, 0);
        read_check(13'h0100, "R3 read from standby with request held");
        repeat (3) @(negedge clk);
        chk(mem_cs == 0, "R3 back to standby after read", mem_cs, 0);
        stby_req = 0;
        read_check(13'h0AAA, "R6 final read");
        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++; n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule